// File: doc/BRIEF.md
# EEE Capability Check Sequencer

This block is a management-side controller. It decides whether Energy-Efficient Ethernet may be switched on for the link that has just come up. A single `start` pulse, issued after link-up, runs one check. The block first looks at the duplex state and the MAC interface type. When those permit EEE, it reads the EEE-related extended registers of the PHY over a simple register-access master port. It intersects the three ability masks it reads and tests the result against the bit that belongs to the resolved link speed.

Every extended register access goes through the clause-22 indirect window, which is a control register plus a data register. When the check succeeds and the caller asked for it, the block also sets the clock-stop-enable bit in the PCS control register with a read-modify-write. A separate request fetches the PHY's wake-error counter.

Top module: `eee_gate_seq`

## Requirements
- R1: A `start` is gated. If `full_duplex` is low, or `if_kind` is 3, the block pulses `done` on the next cycle with `eee_on` low and `err` low, and it issues no access. The `if_kind` codes are 0 = MII, 1 = GMII, 2 = RGMII and 3 = other.
- R2: Each extended access is four port transactions, in this order:
  - write register 13 with the device number;
  - write register 14 with the register number;
  - write register 13 with the device number OR 0x4000;
  - read or write register 14 with the data.

  The next transaction waits for `acc_ack`. While a request is unacknowledged, `acc_req`, `acc_wr`, `acc_reg` and `acc_wdata` stay stable.
- R3: An ungated check reads device 3 register 20 (capability) first. It then reads device 7 register 61 (partner ability), and then device 7 register 60 (local advertisement).
- R4: The ability bits are 0x0002 for 100BASE-TX, 0x0004 for 1000BASE-T, 0x0008 for 10GBASE-T, 0x0010 for 1000BASE-KX, 0x0020 for 10GBASE-KX4 and 0x0040 for 10GBASE-KR. If none of these bits is set in the capability read, the check finishes disabled after that one access.
- R5: `link_speed` selects the bit that is tested:
  - 0 selects 100M (bit 0x0002);
  - 1 selects 1G (bit 0x0004);
  - 2 selects 10G, where `media` picks the bit: 0 for 0x0008, 1 for 0x0020, 2 for 0x0040;
  - 3 selects no bit.

  `eee_on` is set only when the selected bit is present in all three reads.
- R6: On the enabled path with `clkstop_req` high, the block reads device 3 register 0 and writes it back with bit 10 (0x0400) set, before `done`. On any other path, register 0 is not accessed.
- R7: If `acc_rerr` is high together with `acc_ack` during a check, the sequence stops. No further transaction is issued, and `done` pulses with `err` high and `eee_on` low.
- R8: `done` is a one-cycle pulse. `eee_on` and `err` keep their values until the next `start`.
- R9: In idle, a `werr_req` reads device 3 register 22. The block then pulses `werr_valid` with the data on `werr_cnt`, and `werr_fail` reflects a read error. A `start` in the same cycle takes precedence, and that `werr_req` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: run one EEE check |
| full_duplex | input | 1 | Resolved duplex is full |
| if_kind | input | 2 | MAC interface type code |
| link_speed | input | 2 | Resolved speed code |
| media | input | 2 | 10G media selector |
| clkstop_req | input | 1 | Set clock-stop enable when EEE is enabled |
| werr_req | input | 1 | Pulse: read the wake-error counter |
| done | output | 1 | Check finished (one cycle) |
| eee_on | output | 1 | EEE may be enabled |
| err | output | 1 | Check aborted on a read error |
| werr_valid | output | 1 | Wake-error result valid (one cycle) |
| werr_fail | output | 1 | Wake-error read failed |
| werr_cnt | output | 16 | Wake-error counter value |
| acc_req | output | 1 | Register access request |
| acc_wr | output | 1 | Access is a write |
| acc_reg | output | 5 | Clause-22 register number |
| acc_wdata | output | 16 | Write data |
| acc_ack | input | 1 | Access acknowledge |
| acc_rdata | input | 16 | Read data, valid with acknowledge |
| acc_rerr | input | 1 | Read error, valid with acknowledge |

## Verification
The bench models a PHY that decodes the indirect window, so a wrong step order or a missing function code would read the wrong register and give the wrong decision. The bench goes after several corner cases:
- A partner that lacks only the current speed's bit. A design that ORed the masks instead of ANDing them would wrongly enable EEE here.
- A 10G link whose media points at a bit that only the other register copies carry.
- An unknown speed code.
- A read error in mid-sequence. A design that ignored it would keep issuing accesses or report EEE enabled.
- `start` and `werr_req` arriving together. A design with the wrong priority would emit a counter read.

// File: rtl/eee_pkg.sv
package eee_pkg;
  localparam int DW = 16;
  localparam int RW = 5;

  // indirect window registers and function code
  localparam logic [RW-1:0] WIN_CTL = 5'd13;
  localparam logic [RW-1:0] WIN_DAT = 5'd14;
  localparam logic [DW-1:0] FN_DATA = 16'h4000;

  localparam logic [4:0] DEV_PCS = 5'd3;
  localparam logic [4:0] DEV_AN  = 5'd7;
  localparam logic [DW-1:0] R_CTRL1 = 16'd0;
  localparam logic [DW-1:0] R_CAP   = 16'd20;
  localparam logic [DW-1:0] R_WERR  = 16'd22;
  localparam logic [DW-1:0] R_ADV   = 16'd60;
  localparam logic [DW-1:0] R_LPA   = 16'd61;

  localparam logic [DW-1:0] B_100TX  = 16'h0002;
  localparam logic [DW-1:0] B_1000T  = 16'h0004;
  localparam logic [DW-1:0] B_10GT   = 16'h0008;
  localparam logic [DW-1:0] B_1000KX = 16'h0010;
  localparam logic [DW-1:0] B_10GKX4 = 16'h0020;
  localparam logic [DW-1:0] B_10GKR  = 16'h0040;
  localparam logic [DW-1:0] B_KNOWN  = B_100TX | B_1000T | B_10GT | B_1000KX | B_10GKX4 | B_10GKR;
  localparam logic [DW-1:0] B_CLKSTOP = 16'h0400;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAP, ST_LPA, ST_ADV, ST_CRD, ST_CWR, ST_WERR
  } seq_st_t;
endpackage

// File: rtl/eee_win.sv
module eee_win
  import eee_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          op_wr,
  input  logic [4:0]    op_dev,
  input  logic [DW-1:0] op_reg,
  input  logic [DW-1:0] op_wdata,
  output logic          fin,
  output logic          bad,
  output logic [DW-1:0] rdata,
  output logic          acc_req,
  output logic          acc_wr,
  output logic [RW-1:0] acc_reg,
  output logic [DW-1:0] acc_wdata,
  input  logic          acc_ack,
  input  logic [DW-1:0] acc_rdata,
  input  logic          acc_rerr
);
  localparam logic [1:0] LAST = 2'd3;

  logic          act_q, act_n;
  logic [1:0]    step_q, step_n;
  logic          wr_q, wr_n;
  logic [4:0]    dev_q, dev_n;
  logic [DW-1:0] reg_q, reg_n, wd_q, wd_n, rd_q, rd_n;
  logic          fin_q, fin_n, bad_q, bad_n;

  always_comb begin
    act_n = act_q; step_n = step_q; wr_n = wr_q; dev_n = dev_q;
    reg_n = reg_q; wd_n = wd_q; rd_n = rd_q;
    fin_n = 1'b0;  bad_n = bad_q;
    if (!act_q && go) begin
      act_n = 1'b1; step_n = 2'd0; wr_n = op_wr; dev_n = op_dev;
      reg_n = op_reg; wd_n = op_wdata;
    end else if (act_q && acc_ack) begin
      if (acc_rerr) begin
        act_n = 1'b0; fin_n = 1'b1; bad_n = 1'b1;
      end else if (step_q == LAST) begin
        act_n = 1'b0; fin_n = 1'b1; bad_n = 1'b0;
        if (!wr_q) rd_n = acc_rdata;
      end else begin
        step_n = step_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; step_q <= '0; wr_q <= 1'b0; dev_q <= '0;
      reg_q <= '0; wd_q <= '0; rd_q <= '0; fin_q <= 1'b0; bad_q <= 1'b0;
    end else begin
      act_q <= act_n; step_q <= step_n; wr_q <= wr_n; dev_q <= dev_n;
      reg_q <= reg_n; wd_q <= wd_n; rd_q <= rd_n; fin_q <= fin_n; bad_q <= bad_n;
    end
  end

  always_comb begin
    acc_req = act_q;
    acc_wr  = (step_q != LAST) || wr_q;
    acc_reg = step_q[0] ? WIN_DAT : WIN_CTL;
    unique case (step_q)
      2'd0:    acc_wdata = DW'(dev_q);
      2'd1:    acc_wdata = reg_q;
      2'd2:    acc_wdata = DW'(dev_q) | FN_DATA;
      default: acc_wdata = wd_q;
    endcase
  end

  assign fin   = fin_q;
  assign bad   = bad_q;
  assign rdata = rd_q;
endmodule

// File: rtl/eee_lane_pick.sv
module eee_lane_pick
  import eee_pkg::*;
(
  input  logic [1:0]    speed,
  input  logic [1:0]    media,
  output logic [DW-1:0] mask
);
  always_comb begin
    unique case (speed)
      2'd0: mask = B_100TX;
      2'd1: mask = B_1000T;
      2'd2: begin
        unique case (media)
          2'd0:    mask = B_10GT;
          2'd1:    mask = B_10GKX4;
          2'd2:    mask = B_10GKR;
          default: mask = '0;
        endcase
      end
      default: mask = '0;
    endcase
  end
endmodule

// File: rtl/eee_gate_seq.sv
module eee_gate_seq
  import eee_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          full_duplex,
  input  logic [1:0]    if_kind,
  input  logic [1:0]    link_speed,
  input  logic [1:0]    media,
  input  logic          clkstop_req,
  input  logic          werr_req,
  output logic          done,
  output logic          eee_on,
  output logic          err,
  output logic          werr_valid,
  output logic          werr_fail,
  output logic [15:0]   werr_cnt,
  output logic          acc_req,
  output logic          acc_wr,
  output logic [4:0]    acc_reg,
  output logic [15:0]   acc_wdata,
  input  logic          acc_ack,
  input  logic [15:0]   acc_rdata,
  input  logic          acc_rerr
);
  seq_st_t       st_q, st_n;
  logic          done_q, done_n, on_q, on_n, err_q, err_n, ck_q, ck_n;
  logic          wv_q, wv_n, wf_q, wf_n;
  logic [DW-1:0] cap_q, cap_n, lp_q, lp_n, mask_q, mask_n, wc_q, wc_n;
  logic          go, owr, fin, bad;
  logic [4:0]    odev;
  logic [DW-1:0] oreg, owd, rdata, pick;
  logic          gate_ok, seq_idle;

  assign gate_ok  = full_duplex && (if_kind != 2'd3);
  assign seq_idle = (st_q == ST_IDLE);

  eee_lane_pick u_pick (.speed(link_speed), .media(media), .mask(pick));

  eee_win u_win (
    .clk(clk), .rst_n(rst_n), .go(go), .op_wr(owr), .op_dev(odev),
    .op_reg(oreg), .op_wdata(owd), .fin(fin), .bad(bad), .rdata(rdata),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_reg(acc_reg),
    .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
    .acc_rerr(acc_rerr)
  );

  always_comb begin
    st_n = st_q; done_n = 1'b0; on_n = on_q; err_n = err_q;
    cap_n = cap_q; lp_n = lp_q; mask_n = mask_q; ck_n = ck_q;
    wv_n = 1'b0; wf_n = 1'b0; wc_n = wc_q;
    go = 1'b0; owr = 1'b0; odev = '0; oreg = '0; owd = '0;
    if (st_q == ST_IDLE) begin
      if (start) begin
        on_n = 1'b0; err_n = 1'b0;
        if (gate_ok) begin
          mask_n = pick; ck_n = clkstop_req;
          go = 1'b1; odev = DEV_PCS; oreg = R_CAP; st_n = ST_CAP;
        end else begin
          done_n = 1'b1;
        end
      end else if (werr_req) begin
        go = 1'b1; odev = DEV_PCS; oreg = R_WERR; st_n = ST_WERR;
      end
    end else if (fin) begin
      if (st_q == ST_WERR) begin
        wv_n = 1'b1; wf_n = bad; wc_n = rdata; st_n = ST_IDLE;
      end else if (bad) begin
        err_n = 1'b1; on_n = 1'b0; done_n = 1'b1; st_n = ST_IDLE;
      end else begin
        unique case (st_q)
          ST_CAP: begin
            if ((rdata & B_KNOWN) == '0) begin
              done_n = 1'b1; st_n = ST_IDLE;
            end else begin
              cap_n = rdata & mask_q;
              go = 1'b1; odev = DEV_AN; oreg = R_LPA; st_n = ST_LPA;
            end
          end
          ST_LPA: begin
            lp_n = rdata;
            go = 1'b1; odev = DEV_AN; oreg = R_ADV; st_n = ST_ADV;
          end
          ST_ADV: begin
            if ((cap_q & lp_q & rdata) == '0) begin
              done_n = 1'b1; st_n = ST_IDLE;
            end else if (ck_q) begin
              go = 1'b1; odev = DEV_PCS; oreg = R_CTRL1; st_n = ST_CRD;
            end else begin
              on_n = 1'b1; done_n = 1'b1; st_n = ST_IDLE;
            end
          end
          ST_CRD: begin
            go = 1'b1; owr = 1'b1; odev = DEV_PCS; oreg = R_CTRL1;
            owd = rdata | B_CLKSTOP; st_n = ST_CWR;
          end
          default: begin
            on_n = 1'b1; done_n = 1'b1; st_n = ST_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; done_q <= 1'b0; on_q <= 1'b0; err_q <= 1'b0;
      cap_q <= '0; lp_q <= '0; mask_q <= '0; ck_q <= 1'b0;
      wv_q <= 1'b0; wf_q <= 1'b0; wc_q <= '0;
    end else begin
      st_q <= st_n; done_q <= done_n; on_q <= on_n; err_q <= err_n;
      cap_q <= cap_n; lp_q <= lp_n; mask_q <= mask_n; ck_q <= ck_n;
      wv_q <= wv_n; wf_q <= wf_n; wc_q <= wc_n;
    end
  end

  assign done       = done_q;
  assign eee_on     = on_q;
  assign err        = err_q;
  assign werr_valid = wv_q;
  assign werr_fail  = wf_q;
  assign werr_cnt   = wc_q;
endmodule

// File: rtl/eee_gate_chk.sv
module eee_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        full_duplex,
  input logic [1:0]  if_kind,
  input logic        seq_idle,
  input logic        done,
  input logic        eee_on,
  input logic        acc_req,
  input logic        acc_ack,
  input logic        acc_rerr,
  input logic        acc_wr,
  input logic [4:0]  acc_reg,
  input logic [15:0] acc_wdata
);
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle && start && !(full_duplex && if_kind != 2'd3) |=> done && !eee_on && !acc_req);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_wr) && $stable(acc_reg) && $stable(acc_wdata));

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> !acc_req);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_ack && acc_rerr |=> !acc_req);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind eee_gate_seq eee_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .full_duplex(full_duplex),
  .if_kind(if_kind), .seq_idle(seq_idle), .done(done), .eee_on(eee_on),
  .acc_req(acc_req), .acc_ack(acc_ack), .acc_rerr(acc_rerr),
  .acc_wr(acc_wr), .acc_reg(acc_reg), .acc_wdata(acc_wdata)
);

// File: tb/sim_eee_gate_seq.sv
`timescale 1ns/1ps
module sim_eee_gate_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, full_duplex, clkstop_req, werr_req;
  logic [1:0] if_kind, link_speed, media;
  logic done, eee_on, err, werr_valid, werr_fail;
  logic [15:0] werr_cnt, acc_wdata, acc_rdata;
  logic acc_req, acc_wr, acc_ack, acc_rerr;
  logic [4:0] acc_reg;

  eee_gate_seq u0 (.*);

  int total = 0, bad = 0;
  bit ended = 0;
  logic [15:0] mem [int];
  int exp_acc[$];
  bit sb_on[$], sb_err[$];
  string sb_tag[$];
  int err_key = -1;
  int nacc = 0;
  int proto_bad = 0;

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int ac(bit w, int d, int r);
    return (int'(w) << 15) | (d << 10) | r;
  endfunction

  function automatic int key(int d, int r);
    return d * 1024 + r;
  endfunction

  // PHY model behind the indirect window; checks accesses against expectations
  logic [15:0] ctl, ptr;
  initial begin
    acc_ack = 1'b0; acc_rerr = 1'b0; acc_rdata = '0; ctl = '0; ptr = '0;
    forever begin
      @(negedge clk);
      if (acc_ack) begin
        acc_ack = 1'b0; acc_rerr = 1'b0;
      end else if (rst_n && acc_req) begin
        if (acc_reg == 5'd13) begin
          if (acc_wr) ctl = acc_wdata;
        end else if (acc_reg == 5'd14) begin
          if (ctl[15:14] == 2'b00) begin
            if (acc_wr) ptr = acc_wdata;
          end else begin
            int c, k;
            c = ac(acc_wr, int'(ctl[4:0]), int'(ptr[9:0]));
            k = key(int'(ctl[4:0]), int'(ptr[9:0]));
            nacc++;
            if (ctl[15:14] != 2'b01) proto_bad++;
            if (exp_acc.size() == 0) chk(0, "R3", "unexpected access", c, 0);
            else begin
              int e;
              e = exp_acc.pop_front();
              chk(c == e, "R3", "access order", c, e);
            end
            if (acc_wr) mem[k] = acc_wdata;
            else begin
              acc_rdata = mem.exists(k) ? mem[k] : 16'h0000;
              if (k == err_key) acc_rerr = 1'b1;
            end
          end
        end
        acc_ack = 1'b1;
      end
    end
  end

  // monitor: pops scoreboard on every done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_on.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          bit eo, ee; string t;
          eo = sb_on.pop_front(); ee = sb_err.pop_front(); t = sb_tag.pop_front();
          chk(eee_on == eo, t, "eee_on", eee_on, eo);
          chk(err == ee, t, "err", err, ee);
        end
      end
    end
  end

  task automatic run_eee(string t, bit fd, logic [1:0] ik, logic [1:0] sp,
                         logic [1:0] md, bit ck, bit eo, bit ee);
    int n;
    sb_on.push_back(eo); sb_err.push_back(ee); sb_tag.push_back(t);
    @(negedge clk);
    full_duplex = fd; if_kind = ik; link_speed = sp; media = md; clkstop_req = ck;
    start = 1'b1; nacc = 0;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (sb_on.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    if (sb_on.size() != 0) begin
      chk(0, t, "no done", 0, 1);
      sb_on.delete(); sb_err.delete(); sb_tag.delete();
    end
    chk(exp_acc.size() == 0, "R3", "missing accesses", exp_acc.size(), 0);
    exp_acc.delete();
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
    chk(eee_on == eo, "R8", "eee_on held", eee_on, eo);
  endtask

  task automatic load(logic [15:0] cap, logic [15:0] lp, logic [15:0] adv);
    mem.delete();
    mem[key(3,20)] = cap; mem[key(7,61)] = lp; mem[key(7,60)] = adv;
    mem[key(3,0)] = 16'h2040; mem[key(3,22)] = 16'h0017;
  endtask

  task automatic exp3();
    exp_acc.push_back(ac(0,3,20)); exp_acc.push_back(ac(0,7,61)); exp_acc.push_back(ac(0,7,60));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WD", "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 0; werr_req = 0; full_duplex = 0; if_kind = 0;
    link_speed = 0; media = 0; clkstop_req = 0;
    repeat (4) @(negedge clk);
    chk(done == 0 && eee_on == 0 && err == 0 && acc_req == 0 && werr_valid == 0,
        "R8", "reset state", {done, eee_on, err, acc_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 gating
    load(16'h0006, 16'h0006, 16'h0006);
    run_eee("R1", 0, 2'd1, 2'd1, 2'd0, 1, 0, 0);
    chk(nacc == 0, "R1", "half duplex accesses", nacc, 0);
    run_eee("R1", 1, 2'd3, 2'd1, 2'd0, 1, 0, 0);
    chk(nacc == 0, "R1", "other interface accesses", nacc, 0);

    // R4 empty capability (unknown bit only)
    load(16'h0081, 16'h0006, 16'h0006);
    exp_acc.push_back(ac(0,3,20));
    run_eee("R4", 1, 2'd0, 2'd1, 2'd0, 0, 0, 0);
    chk(nacc == 1, "R4", "single access", nacc, 1);

    // R3/R5 1G enabled, RGMII
    load(16'h0006, 16'h0004, 16'h0006);
    exp3();
    run_eee("R5", 1, 2'd2, 2'd1, 2'd0, 0, 1, 0);

    // R5 partner lacks 1G bit
    load(16'h0006, 16'h0002, 16'h0006);
    exp3();
    run_eee("R5", 1, 2'd1, 2'd1, 2'd0, 1, 0, 0);

    // R6 10G KR with clock stop
    load(16'h0040, 16'h0040, 16'h0040);
    exp3(); exp_acc.push_back(ac(0,3,0)); exp_acc.push_back(ac(1,3,0));
    run_eee("R6", 1, 2'd1, 2'd2, 2'd2, 1, 1, 0);
    chk(mem[key(3,0)] == 16'h2440, "R6", "ctrl1 written", mem[key(3,0)], 16'h2440);
    chk(proto_bad == 0, "R2", "function code", proto_bad, 0);

    // R5/R6 10G twisted pair selected but only KR bits: off, ctrl1 untouched
    load(16'h0040, 16'h0040, 16'h0040);
    exp3();
    run_eee("R6", 1, 2'd0, 2'd2, 2'd0, 1, 0, 0);
    chk(mem[key(3,0)] == 16'h2040, "R6", "ctrl1 untouched", mem[key(3,0)], 16'h2040);

    // R5 10G KX4 and 100M
    load(16'h0020, 16'h0020, 16'h0060);
    exp3();
    run_eee("R5", 1, 2'd0, 2'd2, 2'd1, 0, 1, 0);
    load(16'h0002, 16'h0002, 16'h0002);
    exp3();
    run_eee("R5", 1, 2'd0, 2'd0, 2'd0, 0, 1, 0);
    chk(mem[key(3,0)] == 16'h2040, "R6", "no clkstop when not asked", mem[key(3,0)], 16'h2040);

    // R5 undefined speed code
    load(16'h007E, 16'h007E, 16'h007E);
    exp3();
    run_eee("R5", 1, 2'd0, 2'd3, 2'd0, 0, 0, 0);

    // R7 read error on partner read
    load(16'h0004, 16'h0004, 16'h0004);
    err_key = key(7,61);
    exp_acc.push_back(ac(0,3,20)); exp_acc.push_back(ac(0,7,61));
    run_eee("R7", 1, 2'd1, 2'd1, 2'd0, 1, 0, 1);
    chk(nacc == 2, "R7", "stopped after error", nacc, 2);
    err_key = -1;

    // R9 wake error counter
    begin
      int n;
      bit seen;
      exp_acc.push_back(ac(0,3,22));
      @(negedge clk); werr_req = 1'b1;
      @(negedge clk); werr_req = 1'b0;
      n = 0; seen = 0;
      while (!seen && n < 500) begin
        @(negedge clk); n++;
        if (werr_valid) begin
          seen = 1;
          chk(werr_cnt == 16'h0017, "R9", "werr_cnt", werr_cnt, 16'h0017);
          chk(werr_fail == 0, "R9", "werr_fail", werr_fail, 0);
        end
      end
      chk(seen, "R9", "werr_valid", seen, 1);
      chk(exp_acc.size() == 0, "R9", "werr access", exp_acc.size(), 0);
      exp_acc.delete();
    end

    // R9 start beats werr_req in the same cycle
    begin
      bit any;
      sb_on.push_back(0); sb_err.push_back(0); sb_tag.push_back("R9");
      @(negedge clk);
      full_duplex = 0; start = 1'b1; werr_req = 1'b1; nacc = 0;
      @(negedge clk);
      start = 1'b0; werr_req = 1'b0;
      any = 0;
      repeat (40) begin @(negedge clk); if (werr_valid) any = 1; end
      chk(!any, "R9", "werr dropped", any, 0);
      chk(nacc == 0, "R9", "no access", nacc, 0);
      chk(sb_on.size() == 0, "R9", "start served", sb_on.size(), 0);
    end

    finish_run();
  end
endmodule